// File: doc/BRIEF.md
# Outbound Request Ordering Arbiter

This block keeps outbound transactions waiting in three per-class queues (posted writes, non-posted requests and completions) and picks at most one of them each cycle to send downstream. When nothing is blocked, requests leave strictly in the order they were accepted. A request may overtake an older one only when two things are true. First, the older request's class has no room downstream. Second, the class pairing allows the overtake, in some cases only when the younger request carries its relaxed-ordering flag.

Requests enter through a valid/ready port. A request is taken on a rising clock edge when `in_valid` and `in_ready` are both high. `in_ready` depends combinationally on `in_class`: it is low only while the queue for the offered class is full. The sender must hold the request steady until it is taken. Each class has a plain `buf_free` level input that reports whether that class's downstream buffer can take a request. The output is an issue strobe: when `out_valid` is high, the request shown on `out_class`, `out_ro` and `out_data` is sent on that clock edge with no further handshake. It is never offered unless its class's `buf_free` bit is high.

Top module: `txn_order_arb`

## Requirements
- R1: With every `buf_free` bit high, requests are issued one per cycle in exactly the order they were accepted, across all classes.
- R2: `out_valid` is high only for a request whose class has its `buf_free` bit high (bit 0 posted, bit 1 non-posted, bit 2 completion). That request is removed from its queue on the clock edge where it is shown.
- R3: A posted request (class code 0) may overtake older non-posted requests and older completions that are blocked. Posted requests stay in order among themselves.
- R4: A completion (class code 2) may overtake a blocked older non-posted request whatever its RO flag. Completions stay in order among themselves.
- R5: A completion overtakes a blocked older posted request only when its `in_ro` flag was 1. With the flag at 0 it waits.
- R6: A non-posted request (class code 1) never overtakes an older posted or an older non-posted request.
- R7: A non-posted request overtakes a blocked older completion only when its RO flag was 1.
- R8: Each class queue holds 4 requests. `in_ready` is low while the offered class's queue is full, and a request offered then is not taken. Other classes keep accepting.
- R9: A request with class code 3 is accepted (`in_ready` high) and discarded, and it never appears at the output.
- R10: After reset all queues are empty, `in_ready` is high and `out_valid` is low. An accepted request can be issued at the earliest in the cycle after the edge that took it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | A request is offered |
| in_ready | output | 1 | The offered request can be taken this cycle |
| in_class | input | 2 | Class: 0 posted, 1 non-posted, 2 completion, 3 discard |
| in_ro | input | 1 | Relaxed-ordering flag of the offered request |
| in_data | input | 16 | Request payload |
| buf_free | input | 3 | Per-class downstream room, bit index = class code |
| out_valid | output | 1 | A request is issued on this clock edge |
| out_class | output | 2 | Class of the issued request |
| out_ro | output | 1 | Relaxed-ordering flag of the issued request |
| out_data | output | 16 | Payload of the issued request |

## Verification
The ordering state is a set of per-entry counts that record how many requests of each other class are older. A count that is too high holds back a request that should have gone: in the same cycle the blocked class is released, `out_valid` stays low or a younger request comes out first. A count that is too low, or a wrong decrement, shows up as an overtake that the class rules forbid. This is visible in the very cycle the younger request's class becomes free while an older one is blocked. A fault in the queue pointers or fill level shows as a repeated, lost or reordered payload, or as `in_ready` falling at the wrong fill.

// File: rtl/ord_pkg.sv
package ord_pkg;

  localparam int NUM_CLS = 3;

  typedef enum logic [1:0] {
    CLS_POST = 2'd0,
    CLS_NONP = 2'd1,
    CLS_CPL  = 2'd2,
    CLS_DROP = 2'd3
  } req_class_e;

  // Whether a request of class young (with its relaxed-ordering flag) may be
  // issued ahead of an older request of class old. Same-class pairs are never
  // asked: each class queue is first-in first-out.
  function automatic logic may_pass(input int young, input logic young_ro, input int old);
    logic ok;
    ok = 1'b0;
    if (young == int'(CLS_POST)) begin
      ok = (old != int'(CLS_POST));
    end else if (young == int'(CLS_CPL)) begin
      ok = (old == int'(CLS_NONP)) || ((old == int'(CLS_POST)) && young_ro);
    end else if (young == int'(CLS_NONP)) begin
      ok = (old == int'(CLS_CPL)) && young_ro;
    end
    return ok;
  endfunction

endpackage

// File: rtl/ord_class_q.sv
module ord_class_q #(
  parameter int DEPTH = 4,
  parameter int PW    = 16,
  parameter int NCLS  = 3,
  parameter int CW    = 3
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      push,
  input  logic                      push_ro,
  input  logic [PW-1:0]             push_data,
  input  logic [NCLS-1:0][CW-1:0]   push_age,
  input  logic                      pop,
  input  logic [NCLS-1:0]           any_pop,
  output logic                      empty,
  output logic                      full,
  output logic [CW-1:0]             level,
  output logic                      head_ro,
  output logic [PW-1:0]             head_data,
  output logic [NCLS-1:0][CW-1:0]   head_age
);

  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [AW-1:0] LAST_IDX = AW'(DEPTH - 1);
  localparam logic [CW-1:0] FULL_LVL = CW'(DEPTH);

  logic [PW-1:0]           data_mem [DEPTH];
  logic                    ro_mem   [DEPTH];
  logic [NCLS-1:0][CW-1:0] age_mem  [DEPTH];
  logic [AW-1:0]           rd_ptr, wr_ptr;

  function automatic logic [AW-1:0] ptr_next(input logic [AW-1:0] p);
    return (p == LAST_IDX) ? '0 : p + 1'b1;
  endfunction

  assign empty     = (level == '0);
  assign full      = (level == FULL_LVL);
  assign head_ro   = ro_mem[rd_ptr];
  assign head_data = data_mem[rd_ptr];
  assign head_age  = age_mem[rd_ptr];

  // Pointers, fill level and the per-entry "older requests of class q" counts.
  // An issue from class q removes q's oldest entry, which is older than every
  // entry here holding a nonzero count for q.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      level  <= '0;
      for (int i = 0; i < DEPTH; i++) age_mem[i] <= '0;
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        for (int q = 0; q < NCLS; q++) begin
          if (any_pop[q] && (age_mem[i][q] != '0)) age_mem[i][q] <= age_mem[i][q] - 1'b1;
        end
      end
      if (push) begin
        age_mem[wr_ptr] <= push_age;
        wr_ptr          <= ptr_next(wr_ptr);
      end
      if (pop) rd_ptr <= ptr_next(rd_ptr);
      case ({push, pop})
        2'b10:   level <= level + 1'b1;
        2'b01:   level <= level - 1'b1;
        default: level <= level;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (push) begin
      data_mem[wr_ptr] <= push_data;
      ro_mem[wr_ptr]   <= push_ro;
    end
  end

  assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
    level <= FULL_LVL);

  assert_no_underflow_R2: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty);

  assert_full_stalls_push_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !pop) |=> $stable(level) || $fell(full));

endmodule

// File: rtl/ord_pick.sv
module ord_pick
  import ord_pkg::*;
#(
  parameter int NCLS = 3,
  parameter int CW   = 3
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic [NCLS-1:0]                   nonempty,
  input  logic [NCLS-1:0]                   buf_free,
  input  logic [NCLS-1:0]                   head_ro,
  input  logic [NCLS-1:0][NCLS-1:0][CW-1:0] head_age,
  output logic [NCLS-1:0]                   sel
);

  logic [NCLS-1:0] elig;

  // A head is eligible when its class has room and every class holding an
  // older request is one it is allowed to overtake.
  always_comb begin
    for (int c = 0; c < NCLS; c++) begin
      elig[c] = nonempty[c] & buf_free[c];
      for (int q = 0; q < NCLS; q++) begin
        if ((head_age[c][q] != '0) && ((q == c) || !may_pass(c, head_ro[c], q))) elig[c] = 1'b0;
      end
    end
  end

  // Among eligible heads, the one with no older eligible head wins.
  always_comb begin
    for (int c = 0; c < NCLS; c++) begin
      sel[c] = elig[c];
      for (int d = 0; d < NCLS; d++) begin
        if (elig[d] && (head_age[c][d] != '0)) sel[c] = 1'b0;
      end
    end
  end

  assert_single_issue_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(sel));

  assert_oldest_wins_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (&buf_free && (nonempty != '0)) |-> (sel != '0));

  assert_cpl_needs_ro_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (sel[CLS_CPL] && !head_ro[CLS_CPL]) |-> (head_age[CLS_CPL][CLS_POST] == '0));

  assert_np_after_post_R6: assert property (@(posedge clk) disable iff (!rst_n)
    sel[CLS_NONP] |-> (head_age[CLS_NONP][CLS_POST] == '0));

  assert_np_cpl_needs_ro_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (sel[CLS_NONP] && !head_ro[CLS_NONP]) |-> (head_age[CLS_NONP][CLS_CPL] == '0));

endmodule

// File: rtl/txn_order_arb.sv
module txn_order_arb
  import ord_pkg::*;
#(
  parameter int DEPTH = 4,
  parameter int PW    = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [1:0]    in_class,
  input  logic          in_ro,
  input  logic [PW-1:0] in_data,
  input  logic [2:0]    buf_free,
  output logic          out_valid,
  output logic [1:0]    out_class,
  output logic          out_ro,
  output logic [PW-1:0] out_data
);

  localparam int NCLS = NUM_CLS;
  localparam int CW   = $clog2(DEPTH + 1);

  logic [NCLS-1:0]                   push, full, empty, head_ro, sel;
  logic [NCLS-1:0][CW-1:0]           level;
  logic [NCLS-1:0][PW-1:0]           head_data;
  logic [NCLS-1:0][NCLS-1:0][CW-1:0] head_age, push_age;

  always_comb begin
    in_ready = 1'b1;
    for (int c = 0; c < NCLS; c++) begin
      push[c] = in_valid && (in_class == 2'(c)) && !full[c];
      if (in_class == 2'(c)) in_ready = !full[c];
    end
  end

  // A new entry records how many requests of each other class remain after
  // this cycle's issue; all of those are older than it.
  always_comb begin
    for (int c = 0; c < NCLS; c++) begin
      for (int q = 0; q < NCLS; q++) begin
        push_age[c][q] = (q == c) ? '0 : level[q] - CW'(sel[q]);
      end
    end
  end

  for (genvar g = 0; g < NCLS; g++) begin : g_q
    ord_class_q #(.DEPTH(DEPTH), .PW(PW), .NCLS(NCLS), .CW(CW)) u_q (
      .clk       (clk),
      .rst_n     (rst_n),
      .push      (push[g]),
      .push_ro   (in_ro),
      .push_data (in_data),
      .push_age  (push_age[g]),
      .pop       (sel[g]),
      .any_pop   (sel),
      .empty     (empty[g]),
      .full      (full[g]),
      .level     (level[g]),
      .head_ro   (head_ro[g]),
      .head_data (head_data[g]),
      .head_age  (head_age[g])
    );
  end

  ord_pick #(.NCLS(NCLS), .CW(CW)) u_pick (
    .clk      (clk),
    .rst_n    (rst_n),
    .nonempty (~empty),
    .buf_free (buf_free),
    .head_ro  (head_ro),
    .head_age (head_age),
    .sel      (sel)
  );

  always_comb begin
    out_valid = |sel;
    out_class = 2'd0;
    out_ro    = 1'b0;
    out_data  = '0;
    for (int c = 0; c < NCLS; c++) begin
      if (sel[c]) begin
        out_class = 2'(c);
        out_ro    = head_ro[c];
        out_data  = head_data[c];
      end
    end
  end

  assert_issue_has_room_R2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ((out_class != 2'd3) && (|(buf_free & (3'b001 << out_class)))));

  assert_drop_not_stored_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (in_class == CLS_DROP)) |-> (push == '0));

endmodule

// File: tb/sim_txn_order_arb.sv
`timescale 1ns/1ps
module sim_txn_order_arb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [1:0]  in_class = 2'd0;
  logic        in_ro = 1'b0;
  logic [15:0] in_data = '0;
  logic [2:0]  buf_free = 3'b000;
  logic        out_valid;
  logic [1:0]  out_class;
  logic        out_ro;
  logic [15:0] out_data;

  int errs = 0;
  int checks = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  txn_order_arb u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_class(in_class), .in_ro(in_ro), .in_data(in_data), .buf_free(buf_free),
    .out_valid(out_valid), .out_class(out_class), .out_ro(out_ro), .out_data(out_data)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // All tasks start just after a falling edge and return just after one.
  task automatic push(input int cls, input bit ro, input int data, input bit exp_rdy, input string req);
    in_valid = 1'b1;
    in_class = 2'(cls);
    in_ro    = ro;
    in_data  = 16'(data);
    #1 chk(req, "in_ready", int'(in_ready), int'(exp_rdy));
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic see(input int cls, input int data, input string req);
    #1;
    chk(req, "out_valid", int'(out_valid), 1);
    chk(req, "out_data", int'(out_data), data);
    chk(req, "out_class", int'(out_class), cls);
    @(negedge clk);
  endtask

  task automatic none(input string req);
    #1 chk(req, "out_valid", int'(out_valid), 0);
    @(negedge clk);
  endtask

  task automatic drain();
    buf_free = 3'b111;
    repeat (16) @(negedge clk);
    buf_free = 3'b000;
  endtask

  task automatic t_reset();
    buf_free = 3'b111;
    #1;
    chk("R10", "in_ready after reset", int'(in_ready), 1);
    chk("R10", "out_valid after reset", int'(out_valid), 0);
    @(negedge clk);
    buf_free = 3'b000;
  endtask

  task automatic t_order();
    push(0, 0, 11, 1, "R1");
    push(1, 0, 12, 1, "R1");
    push(2, 0, 13, 1, "R1");
    push(0, 0, 14, 1, "R1");
    push(2, 1, 15, 1, "R1");
    push(1, 1, 16, 1, "R1");
    buf_free = 3'b111;
    see(0, 11, "R1"); see(1, 12, "R1"); see(2, 13, "R1");
    see(0, 14, "R1"); see(2, 15, "R1"); see(1, 16, "R1");
    none("R1");
    buf_free = 3'b000;
  endtask

  task automatic t_posted();
    push(1, 0, 21, 1, "R3");
    push(2, 0, 22, 1, "R3");
    push(0, 0, 23, 1, "R3");
    push(0, 0, 24, 1, "R3");
    buf_free = 3'b001;
    see(0, 23, "R3"); see(0, 24, "R3");
    none("R2");
    buf_free = 3'b111;
    see(1, 21, "R3"); see(2, 22, "R3");
    buf_free = 3'b000;
  endtask

  task automatic t_cpl_np();
    push(1, 0, 31, 1, "R4");
    push(2, 0, 32, 1, "R4");
    push(2, 1, 33, 1, "R4");
    buf_free = 3'b100;
    see(2, 32, "R4"); see(2, 33, "R4");
    none("R4");
    buf_free = 3'b111;
    see(1, 31, "R4");
    buf_free = 3'b000;
  endtask

  task automatic t_cpl_post();
    push(0, 0, 41, 1, "R5");
    push(2, 0, 42, 1, "R5");
    buf_free = 3'b100;
    none("R5"); none("R5");
    buf_free = 3'b111;
    see(0, 41, "R5"); see(2, 42, "R5");
    buf_free = 3'b000;
    push(0, 0, 43, 1, "R5");
    push(2, 1, 44, 1, "R5");
    buf_free = 3'b100;
    see(2, 44, "R5");
    none("R5");
    buf_free = 3'b111;
    see(0, 43, "R5");
    buf_free = 3'b000;
    // completions keep their own order: a flagged one waits behind an unflagged one
    push(0, 0, 45, 1, "R4");
    push(2, 0, 46, 1, "R4");
    push(2, 1, 47, 1, "R4");
    buf_free = 3'b100;
    none("R4");
    buf_free = 3'b111;
    see(0, 45, "R4"); see(2, 46, "R4"); see(2, 47, "R4");
    buf_free = 3'b000;
  endtask

  task automatic t_np_post();
    push(0, 0, 51, 1, "R6");
    push(1, 1, 52, 1, "R6");
    push(1, 1, 53, 1, "R6");
    buf_free = 3'b010;
    none("R6"); none("R6");
    buf_free = 3'b111;
    see(0, 51, "R6"); see(1, 52, "R6"); see(1, 53, "R6");
    buf_free = 3'b000;
  endtask

  task automatic t_np_cpl();
    push(2, 0, 61, 1, "R7");
    push(1, 0, 62, 1, "R7");
    buf_free = 3'b010;
    none("R7");
    buf_free = 3'b111;
    see(2, 61, "R7"); see(1, 62, "R7");
    buf_free = 3'b000;
    push(2, 0, 63, 1, "R7");
    push(1, 1, 64, 1, "R7");
    buf_free = 3'b010;
    see(1, 64, "R7");
    none("R7");
    buf_free = 3'b111;
    see(2, 63, "R7");
    buf_free = 3'b000;
  endtask

  task automatic t_full();
    push(0, 0, 71, 1, "R8");
    push(0, 0, 72, 1, "R8");
    push(0, 0, 73, 1, "R8");
    push(0, 0, 74, 1, "R8");
    push(0, 0, 75, 0, "R8");
    push(1, 0, 76, 1, "R8");
    buf_free = 3'b111;
    see(0, 71, "R8"); see(0, 72, "R8"); see(0, 73, "R8"); see(0, 74, "R8");
    see(1, 76, "R8");
    none("R8");
    buf_free = 3'b000;
  endtask

  task automatic t_drop();
    push(3, 0, 81, 1, "R9");
    push(3, 1, 82, 1, "R9");
    buf_free = 3'b111;
    none("R9"); none("R9");
    buf_free = 3'b000;
  endtask

  task automatic t_latency();
    buf_free = 3'b111;
    in_valid = 1'b1;
    in_class = 2'd0;
    in_data  = 16'd91;
    #1 chk("R10", "out_valid before accept", int'(out_valid), 0);
    @(negedge clk);
    in_valid = 1'b0;
    see(0, 91, "R10");
    none("R10");
    buf_free = 3'b000;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_order();    drain();
    t_posted();   drain();
    t_cpl_np();   drain();
    t_cpl_post(); drain();
    t_np_post();  drain();
    t_np_cpl();   drain();
    t_full();     drain();
    t_drop();     drain();
    t_latency();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errs++;
      $display("FAIL watchdog run did not complete actual=0 expected=1");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

endmodule